// File: doc/BRIEF.md
# Word-Clock Frequency Tracker

This block holds a local master oscillator at the long-term average rate of an incoming audio word clock. It does not follow that clock's short-term jitter. The master clock runs the block. The incoming word clock is treated as asynchronous: its rising edges are synchronized into the master domain, and the block counts master cycles across a gate made of a fixed number of word-clock periods. It compares that count with the nominal ratio and then moves a tuning code. The code feeds an external resistor-ladder converter, which in turn steers a voltage-controlled crystal oscillator. A higher code gives a faster master oscillator.

Corrections are slow and small. The code moves at most one step per gate, so the gate length sets the correction rate. The defaults are 88200 word-clock periods per gate and 64 master cycles per period. At 44.1 kHz this gives a 2-second gate and a 0.5 Hz update rate, so source jitter above that rate never reaches the code. With a 10-bit code spanning about ±100 ppm, one step is about 0.19 ppm, which is roughly one count of the 5,644,800-cycle gate.

A lock output drives a front-panel indicator. It rises after a run of on-target gates and falls on a large error. It also falls when the source goes silent.

Top module: `freq_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, tune_code is mid-scale (binary 1 followed by zeros, 512 for a 10-bit code) and locked is 0.
- R2: A measurement window opens at a synchronized rising edge of src_wclk and closes at the GATE_EDGES-th rising edge after it. The closing edge opens the next window. The window's count is the number of master cycles between the opening and closing edges. The result of a window is visible on tune_code and locked by the fourth rising edge of mclk after the closing source edge.
- R3: If a window's count exceeds GATE_EDGES*MCLK_PER_EDGE + DEAD_CNT, the master is fast and tune_code decreases by exactly one. If the count is below GATE_EDGES*MCLK_PER_EDGE - DEAD_CNT, tune_code increases by exactly one.
- R4: A window whose count lies within ±DEAD_CNT of the expected count leaves tune_code unchanged.
- R5: tune_code changes only as the result of a closed window, at most once per window, and by no more than one step.
- R6: tune_code saturates at 0 and at its all-ones value and never wraps.
- R7: locked rises when LOCK_WINDOWS (default 3) consecutive windows fall within ±DEAD_CNT.
- R8: A window whose error magnitude is above DEAD_CNT but at most 4*DEAD_CNT keeps locked as it is and restarts the in-band run. A window whose error magnitude is above 4*DEAD_CNT clears locked.
- R9: If no source edge arrives for GATE_EDGES*MCLK_PER_EDGE master cycles, the open window is discarded. In that case locked clears, the in-band run restarts, tune_code is unchanged, and the next source edge opens a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock from the tuned oscillator; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_wclk | input | 1 | Incoming source word clock, asynchronous to mclk |
| tune_code | output | CODE_W (10) | Unsigned tuning code to the ladder converter; higher is faster |
| locked | output | 1 | Tracking converged indicator |

## Verification
The source word clock is driven at a series of periods relative to the master clock. These include exact multiples of the nominal ratio and quarter-cycle offsets that land one count on either side of target, which tells the deadband apart from the first step. The sweep also uses a two-count slow error and a four-count fast error, which separate a moving code from a dropped lock. Eight-count fast and slow errors are held long enough to drive the code into both saturation limits. A silent source tests window discard and the fresh restart.

// File: rtl/ftrk_pkg.sv
package ftrk_pkg;

  // Classification of one closed measurement window
  typedef struct packed {
    logic fast;   // count above target beyond deadband
    logic slow;   // count below target beyond deadband
    logic far;    // count outside the wide band
  } meas_t;

endpackage

// File: rtl/ftrk_edge_sync.sv
module ftrk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  output logic rise_o
);

  logic [SYNC_STAGES:0] shift_q;
  logic [SYNC_STAGES:0] shift_d;

  always_comb begin
    shift_d = {shift_q[SYNC_STAGES-1:0], src_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rise_o = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

  // R2
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ftrk_gate_counter.sv
module ftrk_gate_counter import ftrk_pkg::*; #(
  parameter int GATE_EDGES  = 88200,
  parameter int EXPECT_CNT  = 5644800,
  parameter int DEAD_CNT    = 1,
  parameter int WIDE_CNT    = 4,
  parameter int TIMEOUT_CYC = 5644800,
  parameter int CNT_W       = 24,
  parameter int IDLE_W      = 23
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_i,
  output logic  done_o,
  output meas_t meas_o,
  output logic  stall_o
);

  localparam int EW = (GATE_EDGES > 1) ? $clog2(GATE_EDGES) : 1;
  localparam logic [EW-1:0]     LAST_EDGE  = EW'(GATE_EDGES - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX    = '1;
  localparam logic [IDLE_W-1:0] IDLE_LIMIT = IDLE_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W:0]    HI_DEAD    = (CNT_W+1)'(EXPECT_CNT + DEAD_CNT);
  localparam logic [CNT_W:0]    LO_DEAD    = (CNT_W+1)'(EXPECT_CNT - DEAD_CNT);
  localparam logic [CNT_W:0]    HI_WIDE    = (CNT_W+1)'(EXPECT_CNT + WIDE_CNT);
  localparam logic [CNT_W:0]    LO_WIDE    = (CNT_W+1)'(EXPECT_CNT - WIDE_CNT);

  logic              running_q, running_d;
  logic [EW-1:0]     edges_q,   edges_d;
  logic [CNT_W-1:0]  cyc_q,     cyc_d;
  logic [IDLE_W-1:0] idle_q,    idle_d;
  logic              done_q,    done_d;
  logic              stall_q,   stall_d;
  meas_t             meas_q,    meas_d;
  logic [CNT_W:0]    cnt_ext;

  always_comb begin
    running_d = running_q;
    edges_d   = edges_q;
    cyc_d     = cyc_q;
    meas_d    = meas_q;
    done_d    = 1'b0;
    stall_d   = 1'b0;
    cnt_ext   = '0;

    // idle watchdog on the source
    if (rise_i) begin
      idle_d = '0;
    end else if (idle_q == IDLE_LIMIT) begin
      idle_d    = '0;
      stall_d   = 1'b1;
      running_d = 1'b0;
    end else begin
      idle_d = idle_q + 1'b1;
    end

    // master cycle count inside the open window
    if (running_q && cyc_q != CNT_MAX) begin
      cyc_d = cyc_q + 1'b1;
    end

    if (rise_i) begin
      if (!running_q) begin
        running_d = 1'b1;
        cyc_d     = '0;
        edges_d   = '0;
      end else if (edges_q == LAST_EDGE) begin
        cnt_ext     = {1'b0, cyc_d};
        done_d      = 1'b1;
        meas_d.fast = (cnt_ext > HI_DEAD);
        meas_d.slow = (cnt_ext < LO_DEAD);
        meas_d.far  = (cnt_ext > HI_WIDE) || (cnt_ext < LO_WIDE);
        cyc_d       = '0;
        edges_d     = '0;
      end else begin
        edges_d = edges_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      edges_q   <= '0;
      cyc_q     <= '0;
      idle_q    <= '0;
      done_q    <= 1'b0;
      stall_q   <= 1'b0;
      meas_q    <= '0;
    end else begin
      running_q <= running_d;
      edges_q   <= edges_d;
      cyc_q     <= cyc_d;
      idle_q    <= idle_d;
      done_q    <= done_d;
      stall_q   <= stall_d;
      if (done_d) meas_q <= meas_d;
    end
  end

  assign done_o  = done_q;
  assign stall_o = stall_q;
  assign meas_o  = meas_q;

endmodule

// File: rtl/ftrk_code_ctrl.sv
module ftrk_code_ctrl import ftrk_pkg::*; #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  meas_t             meas_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_d  = code_q;
    code_en = 1'b0;
    if (done_i) begin
      if (meas_i.fast && code_q != '0) begin
        code_d  = code_q - 1'b1;
        code_en = 1'b1;
      end else if (meas_i.slow && code_q != CODE_MAX) begin
        code_d  = code_q + 1'b1;
        code_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CODE_MID;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(code_q));

  // R5
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1 ||
                code_q == $past(code_q) - 1'b1));

  // R6
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MAX) |=> (code_q != '0));

  // R6
  no_wrap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0) |=> (code_q != CODE_MAX));

endmodule

// File: rtl/ftrk_lock_mon.sv
module ftrk_lock_mon import ftrk_pkg::*; #(
  parameter int LOCK_WINDOWS = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  done_i,
  input  logic  stall_i,
  input  meas_t meas_i,
  output logic  locked_o
);

  localparam int SW = $clog2(LOCK_WINDOWS + 1);
  localparam logic [SW-1:0] RUN_FULL = SW'(LOCK_WINDOWS);

  logic [SW-1:0] run_q, run_d, run_inc;
  logic          locked_q, locked_d;

  always_comb begin
    run_d    = run_q;
    locked_d = locked_q;
    run_inc  = (run_q == RUN_FULL) ? run_q : run_q + 1'b1;
    if (stall_i) begin
      run_d    = '0;
      locked_d = 1'b0;
    end else if (done_i) begin
      if (meas_i.far) begin
        run_d    = '0;
        locked_d = 1'b0;
      end else if (meas_i.fast || meas_i.slow) begin
        run_d = '0;
      end else begin
        run_d = run_inc;
        if (run_inc == RUN_FULL) locked_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;

  // R9
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> !locked_q);

  // R8
  far_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && meas_i.far) |=> !locked_q);

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(done_i));

endmodule

// File: rtl/freq_tracker.sv
module freq_tracker import ftrk_pkg::*; #(
  parameter int CODE_W        = 10,
  parameter int GATE_EDGES    = 88200,
  parameter int MCLK_PER_EDGE = 64,
  parameter int DEAD_CNT      = 1,
  parameter int LOCK_WINDOWS  = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              src_wclk,
  output logic [CODE_W-1:0] tune_code,
  output logic              locked
);

  localparam int EXPECT_CNT  = GATE_EDGES * MCLK_PER_EDGE;
  localparam int WIDE_CNT    = 4 * DEAD_CNT;
  localparam int TIMEOUT_CYC = EXPECT_CNT;
  localparam int CNT_W       = $clog2(2 * EXPECT_CNT + 1);
  localparam int IDLE_W      = $clog2(TIMEOUT_CYC + 1);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       src_rise;
  logic       win_done;
  logic       win_stall;
  meas_t      win_meas;

  // asynchronous assert, synchronous release
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ftrk_edge_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (mclk),
    .rst_n  (rst_sync_n),
    .src_i  (src_wclk),
    .rise_o (src_rise)
  );

  ftrk_gate_counter #(
    .GATE_EDGES  (GATE_EDGES),
    .EXPECT_CNT  (EXPECT_CNT),
    .DEAD_CNT    (DEAD_CNT),
    .WIDE_CNT    (WIDE_CNT),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W),
    .IDLE_W      (IDLE_W)
  ) u_gate (
    .clk     (mclk),
    .rst_n   (rst_sync_n),
    .rise_i  (src_rise),
    .done_o  (win_done),
    .meas_o  (win_meas),
    .stall_o (win_stall)
  );

  ftrk_code_ctrl #(
    .CODE_W (CODE_W)
  ) u_code (
    .clk    (mclk),
    .rst_n  (rst_sync_n),
    .done_i (win_done),
    .meas_i (win_meas),
    .code_o (tune_code)
  );

  ftrk_lock_mon #(
    .LOCK_WINDOWS (LOCK_WINDOWS)
  ) u_lock (
    .clk      (mclk),
    .rst_n    (rst_sync_n),
    .done_i   (win_done),
    .stall_i  (win_stall),
    .meas_i   (win_meas),
    .locked_o (locked)
  );

endmodule

// File: tb/freq_tracker_tb.sv
`timescale 1ns/1ps
module freq_tracker_tb;

  localparam real CLK_PERIOD = 10.0;
  localparam int  CODE_W   = 4;
  localparam int  GATE     = 4;
  localparam int  RATIO    = 16;
  localparam int  DEAD     = 1;
  localparam int  LOCK_N   = 3;
  localparam int  EXPECT   = GATE * RATIO;
  localparam int  WIDE     = 4 * DEAD;
  localparam int  CODE_MAX = (1 << CODE_W) - 1;
  localparam int  MID      = 1 << (CODE_W - 1);

  logic              mclk  = 1'b0;
  logic              rst_n = 1'b0;
  logic              src   = 1'b0;
  logic [CODE_W-1:0] tune_code;
  logic              locked;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    code_exp;
  int    run_exp;
  int    lock_exp;
  string win_tag;
  event  win_end;

  freq_tracker #(
    .CODE_W        (CODE_W),
    .GATE_EDGES    (GATE),
    .MCLK_PER_EDGE (RATIO),
    .DEAD_CNT      (DEAD),
    .LOCK_WINDOWS  (LOCK_N),
    .SYNC_STAGES   (2)
  ) u_dut (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .src_wclk  (src),
    .tune_code (tune_code),
    .locked    (locked)
  );

  always #(CLK_PERIOD / 2.0) mclk = ~mclk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One full window of GATE source periods; the model follows R3, R4, R6, R7, R8
  task automatic run_window(input real period, input string tag);
    int cnt;
    int err;
    for (int i = 0; i < GATE; i++) begin
      #(period / 2.0) src = 1'b0;
      #(period / 2.0) src = 1'b1;
    end
    cnt = $rtoi(GATE * period / CLK_PERIOD + 0.5);
    err = cnt - EXPECT;
    if (err > WIDE || err < -WIDE) begin
      run_exp  = 0;
      lock_exp = 0;
    end else if (err > DEAD || err < -DEAD) begin
      run_exp = 0;
    end else begin
      if (run_exp < LOCK_N) run_exp++;
      if (run_exp >= LOCK_N) lock_exp = 1;
    end
    if (err > DEAD && code_exp > 0) code_exp--;
    else if (err < -DEAD && code_exp < CODE_MAX) code_exp++;
    win_tag = tag;
    -> win_end;
  endtask

  // Samples 75 ns after each closing edge, well after the R2 latency
  initial begin
    forever begin
      @(win_end);
      #75;
      chk({win_tag, " code"}, int'(tune_code), code_exp);
      chk({win_tag, " lock"}, int'(locked), lock_exp);
    end
  end

  initial begin
    #(200000 * CLK_PERIOD);
    n_bad++;
    $display("FAIL watchdog: actual still running, expected finished");
    summary();
    $finish;
  end

  initial begin
    code_exp = MID;
    run_exp  = 0;
    lock_exp = 0;

    repeat (3) @(posedge mclk);
    #1;
    chk("R1 code in reset", int'(tune_code), MID);
    chk("R1 lock in reset", int'(locked), 0);
    @(negedge mclk) rst_n = 1'b1;
    repeat (6) @(posedge mclk);
    #2;
    chk("R1 code after release", int'(tune_code), MID);
    chk("R1 lock after release", int'(locked), 0);

    // opening edge, 3 ns past a master edge
    @(posedge mclk);
    #3 src = 1'b1;

    repeat (3) run_window(160.0, "R2/R7 on target");
    repeat (2) run_window(162.5, "R4 deadband plus one");
    repeat (2) run_window(170.0, "R3/R8 moderate fast");
    run_window(155.0, "R3/R8 moderate slow");
    repeat (9) run_window(180.0, "R6/R8 far fast to floor");
    repeat (3) run_window(157.5, "R4/R7 deadband minus one");
    repeat (17) run_window(140.0, "R6/R3 far slow to ceiling");
    repeat (3) run_window(160.0, "R7 relock");

    // R9: silent source
    #80 src = 1'b0;
    #1500;
    run_exp  = 0;
    lock_exp = 0;
    chk("R9 lock after silence", int'(locked), 0);
    chk("R9 code after silence", int'(tune_code), code_exp);
    @(posedge mclk);
    #3 src = 1'b1;
    repeat (3) run_window(160.0, "R9 fresh restart");

    // R1: asynchronous reset mid-run
    #20 rst_n = 1'b0;
    #1;
    chk("R1 code on async reset", int'(tune_code), MID);
    chk("R1 lock on async reset", int'(locked), 0);

    summary();
    $finish;
  end

endmodule